// File: doc/BRIEF.md
# Keyed Countdown Watchdog

This block supervises a processor by counting down once armed and pulsing a reset line if software lets the count run out. Software keeps it quiet by writing two fixed key words, one after the other, to a key register. Any other bus write between the two keys cancels the attempt, so a single stray store cannot refresh the counter. Arming works in one direction only. Once armed, the watchdog stays armed until power-on reset.

The first countdown after arming, and the first after every watchdog-issued reset, uses a separate and longer initial timeout. This gives boot code time to initialise. Each later restart loads the count from a staged reload register. Writes to that register take effect only at the next valid restart.

The block counts every watchdog-issued reset in a saturating failure counter, which only power-on reset clears. When the counter reaches its limit, a sticky give-up flag freezes the watchdog so that it stops issuing resets.

Top module: `wdog_core`

## Requirements
- R1: After `rst` the block is disarmed, the count equals the initial timeout, the reset output is low, and the failure count and give-up flag are zero. While disarmed, the count holds, key writes have no effect and no reset pulse is issued.
- R2: A write to select 2 (control) with data bit 0 set arms the block and loads the count with the initial timeout. When no restart follows, the reset output rises on the clock edge that comes INIT_TIMEOUT+1 edges after the arming write edge. The same initial timeout applies again after every watchdog-issued reset.
- R3: A restart happens when a write of 0x5555 to select 1 (key) is followed by a write of 0xAAAA to select 1 on the next bus write. Cycles with no write in between do not break the pair. A restart loads the count from the staged reload value, and the count then reaches zero after that many edges.
- R4: Any other bus write between the two keys cancels the pair. A lone 0xAAAA does nothing. A repeated 0x5555 starts a fresh pair.
- R5: When a restart lands on the same edge as expiry (count already zero), the restart wins and no reset pulse is issued.
- R6: Once armed, the block cannot be disarmed. A control write with bit 0 clear has no effect.
- R7: A write to select 0 (reload) stages a new reload value without touching the running count. Before any such write, the reload value is RELOAD_DEF.
- R8: If the count is zero while the block is armed, the next edge raises the reset output for exactly PULSE_LEN cycles. On that same edge the count is set to the initial timeout, and it is held there until the pulse ends.
- R9: Each expiry increments the failure count, saturating at FAIL_LIMIT. The give-up flag is set on the expiry that reaches FAIL_LIMIT and stays set. Only `rst` clears either of them.
- R10: While the give-up flag is set, the count is frozen, no reset pulses occur and restarts have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_sel | input | 2 | Register select: 0 reload, 1 key, 2 control |
| wr_data | input | 16 | Write data |
| wdt_reset_o | output | 1 | Processor reset pulse |
| armed_o | output | 1 | Watchdog armed |
| count_o | output | CNT_W | Current countdown value |
| fail_cnt_o | output | FAIL_W | Saturating count of watchdog resets |
| give_up_o | output | 1 | Sticky give-up flag |

## Verification
The bench targets the following corner cases. Each describes what a faulty design would do.

- **Just-in-time restart (R5).** The second key is placed on the very edge where the count reaches zero. A design that gives expiry priority would bite a system that actually refreshed in time.
- **Broken key pairs (R4).** The bench interrupts the pair with a reload write, with a wrong key value, and with a repeated first key. A matcher that only remembers having seen the first key would accept the corrupted pair. A matcher that does not re-start on a repeated first key would reject a legal one.
- **Timing and reload staging (R2, R3, R7).** The bench sweeps reload values and counts edges to each bite and through each pulse, after arming, after a restart and after a previous bite. An off-by-one in the zero test or the pulse length, or a reload that loads immediately, shows up as a wrong cycle count.
- **Give-up behaviour (R9, R10).** After the limit is reached, a design that keeps counting or keeps pulsing is caught, as is one that clears the failure counter on a watchdog reset.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int WD_DATA_W = 16;

    // Register select codes on the write bus.
    typedef enum logic [1:0] {
        WD_SEL_RELOAD = 2'd0,
        WD_SEL_KEY    = 2'd1,
        WD_SEL_CTRL   = 2'd2,
        WD_SEL_NONE   = 2'd3
    } wd_sel_e;

    typedef struct packed {
        logic                 vld;
        wd_sel_e              sel;
        logic [WD_DATA_W-1:0] data;
    } wd_wr_t;

    // True when the bus carries a write of value v to register s.
    function automatic logic wd_hit(input wd_wr_t w, input wd_sel_e s,
                                    input logic [WD_DATA_W-1:0] v);
        return w.vld && (w.sel == s) && (w.data == v);
    endfunction

    function automatic logic wd_to(input wd_wr_t w, input wd_sel_e s);
        return w.vld && (w.sel == s);
    endfunction

endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock
    import wdog_pkg::*;
#(
    parameter logic [WD_DATA_W-1:0] KEY_A = 16'h5555,
    parameter logic [WD_DATA_W-1:0] KEY_B = 16'hAAAA
) (
    input  logic   clk,
    input  logic   rst,
    input  wd_wr_t wr,
    output logic   restart
);

    // Set when the most recent bus write was the first key.
    logic stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= 1'b0;
        end else if (wr.vld) begin
            stage_q <= wd_hit(wr, WD_SEL_KEY, KEY_A);
        end
    end

    assign restart = stage_q && wd_hit(wr, WD_SEL_KEY, KEY_B);

endmodule

// File: rtl/wdog_down.sv
module wdog_down #(
    parameter int CNT_W        = 16,
    parameter int INIT_TIMEOUT = 60000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_req,
    input  logic             restart,
    input  logic             hold,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             armed,
    output logic             expire
);

    localparam logic [CNT_W-1:0] INIT_V = CNT_W'(INIT_TIMEOUT);

    logic [CNT_W-1:0] count_q;
    logic             armed_q;

    // A restart on the zero cycle suppresses expiry.
    assign expire = armed_q && !hold && !restart && (count_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            count_q <= INIT_V;
        end else if (!armed_q) begin
            if (arm_req) begin
                armed_q <= 1'b1;
                count_q <= INIT_V;
            end
        end else if (!hold) begin
            if (restart) begin
                count_q <= reload;
            end else if (count_q == '0) begin
                count_q <= INIT_V;
            end else begin
                count_q <= count_q - 1'b1;
            end
        end
    end

    assign count = count_q;
    assign armed = armed_q;

endmodule

// File: rtl/wdog_bite.sv
module wdog_bite #(
    parameter int PULSE_LEN  = 16,
    parameter int FAIL_LIMIT = 3,
    parameter int FAIL_W     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              expire,
    output logic              pulse,
    output logic [FAIL_W-1:0] fail_cnt,
    output logic              give_up
);

    localparam int                PL_W  = $clog2(PULSE_LEN + 1);
    localparam logic [PL_W-1:0]   PL_V  = PL_W'(PULSE_LEN);
    localparam logic [FAIL_W-1:0] LIM_V = FAIL_W'(FAIL_LIMIT);

    logic [PL_W-1:0]   left_q;
    logic [FAIL_W-1:0] fail_q;
    logic              gu_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            fail_q <= '0;
            gu_q   <= 1'b0;
        end else begin
            if (expire) begin
                left_q <= PL_V;
                if (fail_q != LIM_V) begin
                    fail_q <= fail_q + FAIL_W'(1);
                end
                if (fail_q + FAIL_W'(1) == LIM_V) begin
                    gu_q <= 1'b1;
                end
            end else if (left_q != '0) begin
                left_q <= left_q - PL_W'(1);
            end
        end
    end

    assign pulse    = (left_q != '0);
    assign fail_cnt = fail_q;
    assign give_up  = gu_q;

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int                   CNT_W        = 16,
    parameter int                   INIT_TIMEOUT = 60000,
    parameter int                   RELOAD_DEF   = 20000,
    parameter int                   PULSE_LEN    = 16,
    parameter int                   FAIL_LIMIT   = 3,
    parameter logic [WD_DATA_W-1:0] KEY_A        = 16'h5555,
    parameter logic [WD_DATA_W-1:0] KEY_B        = 16'hAAAA,
    parameter int                   FAIL_W       = $clog2(FAIL_LIMIT + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [WD_DATA_W-1:0] wr_data,
    output logic                 wdt_reset_o,
    output logic                 armed_o,
    output logic [CNT_W-1:0]     count_o,
    output logic [FAIL_W-1:0]    fail_cnt_o,
    output logic                 give_up_o
);

    wd_wr_t           wr;
    logic             restart_w;
    logic             arm_req_w;
    logic             hold_w;
    logic             expire_w;
    logic             pulse_w;
    logic             give_up_w;
    logic [CNT_W-1:0] reload_q;

    assign wr = '{vld: wr_en, sel: wd_sel_e'(wr_sel), data: wr_data};

    // Staged reload value, consumed only by a restart.
    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= CNT_W'(RELOAD_DEF);
        end else if (wd_to(wr, WD_SEL_RELOAD)) begin
            reload_q <= CNT_W'(wr.data);
        end
    end

    assign arm_req_w = wd_to(wr, WD_SEL_CTRL) && wr.data[0];
    assign hold_w    = pulse_w || give_up_w;

    wdog_unlock #(
        .KEY_A (KEY_A),
        .KEY_B (KEY_B)
    ) unlock_i (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .restart (restart_w)
    );

    wdog_down #(
        .CNT_W        (CNT_W),
        .INIT_TIMEOUT (INIT_TIMEOUT)
    ) down_i (
        .clk     (clk),
        .rst     (rst),
        .arm_req (arm_req_w),
        .restart (restart_w),
        .hold    (hold_w),
        .reload  (reload_q),
        .count   (count_o),
        .armed   (armed_o),
        .expire  (expire_w)
    );

    wdog_bite #(
        .PULSE_LEN  (PULSE_LEN),
        .FAIL_LIMIT (FAIL_LIMIT),
        .FAIL_W     (FAIL_W)
    ) bite_i (
        .clk      (clk),
        .rst      (rst),
        .expire   (expire_w),
        .pulse    (pulse_w),
        .fail_cnt (fail_cnt_o),
        .give_up  (give_up_w)
    );

    assign wdt_reset_o = pulse_w;
    assign give_up_o   = give_up_w;

endmodule

// File: rtl/wdog_core_chk.sv
module wdog_core_chk #(
    parameter int CNT_W      = 16,
    parameter int FAIL_W     = 2,
    parameter int PULSE_LEN  = 16,
    parameter int FAIL_LIMIT = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              rst_o,
    input logic              armed,
    input logic              give_up,
    input logic [FAIL_W-1:0] fail_cnt,
    input logic [CNT_W-1:0]  count,
    input logic              restart,
    input logic [CNT_W-1:0]  reload
);

    localparam int RW = $clog2(PULSE_LEN + 2);

    // Length of the current high run of the reset output.
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (rst_o) begin
            if (run_q != RW'(PULSE_LEN + 1)) begin
                run_q <= run_q + RW'(1);
            end
        end else begin
            run_q <= '0;
        end
    end

    assert_quiet_disarmed_R1: assert property (@(posedge clk) disable iff (rst)
        !armed |-> !rst_o);

    assert_restart_load_R3: assert property (@(posedge clk) disable iff (rst)
        (restart && armed && !give_up && !rst_o) |=> count == $past(reload));

    assert_arm_oneway_R6: assert property (@(posedge clk) disable iff (rst)
        armed |=> armed);

    assert_pulse_max_R8: assert property (@(posedge clk) disable iff (rst)
        rst_o |-> run_q < RW'(PULSE_LEN));

    assert_pulse_full_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_o) |-> run_q == RW'(PULSE_LEN));

    assert_fail_nondec_R9: assert property (@(posedge clk) disable iff (rst)
        fail_cnt >= $past(fail_cnt));

    assert_fail_bound_R9: assert property (@(posedge clk) disable iff (rst)
        fail_cnt <= FAIL_W'(FAIL_LIMIT));

    assert_giveup_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        give_up |=> give_up);

    assert_giveup_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (give_up && !rst_o) |=> !rst_o);

endmodule

bind wdog_core wdog_core_chk #(
    .CNT_W      (CNT_W),
    .FAIL_W     (FAIL_W),
    .PULSE_LEN  (PULSE_LEN),
    .FAIL_LIMIT (FAIL_LIMIT)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .rst_o    (wdt_reset_o),
    .armed    (armed_o),
    .give_up  (give_up_o),
    .fail_cnt (fail_cnt_o),
    .count    (count_o),
    .restart  (restart_w),
    .reload   (reload_q)
);

// File: tb/wdog_core_tb_top.sv
`timescale 1ns/1ps
module wdog_core_tb_top;

    localparam int INIT  = 40;
    localparam int RDEF  = 20;
    localparam int PLEN  = 4;
    localparam int LIMIT = 3;
    localparam logic [15:0] KA = 16'h5555;
    localparam logic [15:0] KB = 16'hAAAA;
    localparam logic [1:0] S_RELOAD = 2'd0;
    localparam logic [1:0] S_KEY    = 2'd1;
    localparam logic [1:0] S_CTRL   = 2'd2;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [15:0] wr_data;
    logic        wdt_reset_o;
    logic        armed_o;
    logic [15:0] count_o;
    logic [1:0]  fail_cnt_o;
    logic        give_up_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    wdog_core #(
        .CNT_W        (16),
        .INIT_TIMEOUT (INIT),
        .RELOAD_DEF   (RDEF),
        .PULSE_LEN    (PLEN),
        .FAIL_LIMIT   (LIMIT)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .wdt_reset_o (wdt_reset_o),
        .armed_o     (armed_o),
        .count_o     (count_o),
        .fail_cnt_o  (fail_cnt_o),
        .give_up_o   (give_up_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // All tasks are entered at a falling edge; the write lands on the next rising edge.
    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic seq3(input logic [1:0] s1, input logic [15:0] d1,
                        input logic [1:0] s2, input logic [15:0] d2,
                        input logic [1:0] s3, input logic [15:0] d3);
        wr_en = 1'b1; wr_sel = s1; wr_data = d1;
        @(negedge clk);
        wr_sel = s2; wr_data = d2;
        @(negedge clk);
        wr_sel = s3; wr_data = d3;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic keypair();
        wr_en = 1'b1; wr_sel = S_KEY; wr_data = KA;
        @(negedge clk);
        wr_data = KB;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_bite(output int n);
        n = 0;
        while (!wdt_reset_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pulse_len(output int p);
        p = 0;
        do begin
            p++;
            @(negedge clk);
        end while (wdt_reset_o && p < 100);
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int n;
        int p;
        int c;
        bit seen;
        rst = 1'b1; wr_en = 1'b0; wr_sel = 2'd0; wr_data = 16'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state and idle while disarmed
        chk("R1 reset pulse", int'(wdt_reset_o), 0);
        chk("R1 reset armed", int'(armed_o), 0);
        chk("R1 reset count", int'(count_o), INIT);
        chk("R1 reset fail", int'(fail_cnt_o), 0);
        chk("R1 reset give_up", int'(give_up_o), 0);
        seen = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (wdt_reset_o) seen = 1'b1;
        end
        chk("R1 no pulse disarmed", int'(seen), 0);
        keypair();
        chk("R1 count holds disarmed", int'(count_o), INIT);

        // R6: clear bit does not arm or disarm
        wr(S_CTRL, 16'h0000);
        chk("R6 ctrl zero no arm", int'(armed_o), 0);

        // R2: arm and first timeout
        wr(S_CTRL, 16'h0001);
        chk("R2 armed", int'(armed_o), 1);
        chk("R2 init load", int'(count_o), INIT);
        wait_bite(n);
        chk("R2 first timeout edges", n, INIT + 1);
        chk("R8 count held at init", int'(count_o), INIT);
        chk("R9 fail after first bite", int'(fail_cnt_o), 1);
        pulse_len(p);
        chk("R8 pulse length", p, PLEN);
        chk("R8 count after pulse", int'(count_o), INIT);

        // R6: cannot disarm
        wr(S_CTRL, 16'h0000);
        chk("R6 stays armed", int'(armed_o), 1);

        // R7: default reload
        keypair();
        chk("R7 default reload", int'(count_o), RDEF);

        // R3/R5/R7 sweep over reload values
        for (int r = 2; r <= 15; r++) begin
            c = int'(count_o);
            wr(S_RELOAD, 16'(r));
            chk("R7 staging leaves count", int'(count_o), c - 1);
            keypair();
            chk("R3 restart loads reload", int'(count_o), r);
            repeat (r - 1) @(negedge clk);
            chk("R3 countdown reaches one", int'(count_o), 1);
            keypair();
            chk("R5 restart beats expiry", int'(count_o), r);
            chk("R5 no pulse", int'(wdt_reset_o), 0);
        end
        chk("R5 fail unchanged", int'(fail_cnt_o), 1);

        // R4: broken key pairs
        wr(S_RELOAD, 16'd30);
        keypair();
        chk("R3 reload 30", int'(count_o), 30);
        seq3(S_KEY, KA, S_RELOAD, 16'd30, S_KEY, KB);
        chk("R4 other write breaks", int'(count_o), 27);
        wr(S_KEY, KB);
        chk("R4 lone second key", int'(count_o), 26);
        seq3(S_KEY, KA, S_KEY, KA, S_KEY, KB);
        chk("R4 repeated first key", int'(count_o), 30);
        wr_en = 1'b1; wr_sel = S_KEY; wr_data = KA;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        wr_en = 1'b1; wr_data = KB;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R3 idle gap keeps pair", int'(count_o), 30);
        seq3(S_KEY, KA, S_KEY, 16'h1234, S_KEY, KB);
        chk("R4 wrong key value breaks", int'(count_o), 27);

        // R8: expiry after a restart
        wr(S_RELOAD, 16'd10);
        keypair();
        chk("R3 reload 10", int'(count_o), 10);
        wait_bite(n);
        chk("R8 expiry edges after restart", n, 11);
        chk("R9 fail second", int'(fail_cnt_o), 2);
        chk("R9 no give_up yet", int'(give_up_o), 0);
        pulse_len(p);
        chk("R8 pulse length second", p, PLEN);

        // R2: initial timeout again after a bite
        wait_bite(n);
        chk("R2 init timeout after bite", n, INIT + 1);
        chk("R9 fail at limit", int'(fail_cnt_o), LIMIT);
        chk("R9 give_up set", int'(give_up_o), 1);
        pulse_len(p);
        chk("R8 pulse length third", p, PLEN);

        // R10: frozen after give-up
        seen = 1'b0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (wdt_reset_o) seen = 1'b1;
        end
        chk("R10 no pulse after give_up", int'(seen), 0);
        chk("R10 count frozen", int'(count_o), INIT);
        chk("R10 fail saturated", int'(fail_cnt_o), LIMIT);
        keypair();
        chk("R10 restart ignored", int'(count_o), INIT);
        chk("R9 give_up sticky", int'(give_up_o), 1);

        // R9: only rst clears
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 rst clears fail", int'(fail_cnt_o), 0);
        chk("R9 rst clears give_up", int'(give_up_o), 0);
        chk("R1 rst disarms", int'(armed_o), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule